// File: doc/BRIEF.md
# Dual-Slope PWM Timer

The block is an 8-bit timer that sweeps its count upward from zero to the all-ones value and then back down to zero. A compare unit watches this triangular count and drives a pulse-width-modulated pin that is symmetric about the top of each sweep. One full period spans 510 advances of the count.

Each advance is gated by a single-cycle enable, `tick`, which comes from an external prescaler. Two event flags record when the count leaves zero and when the count meets the compare value. A single interrupt line combines the flags with per-flag enables and one global enable. Software clears a flag by writing a one to it, or the interrupt controller clears it by acknowledging it.

The compare value moves into the active register only at the top of the sweep. A new duty cycle therefore never cuts a pulse short in the middle of a period.

Top module: `phase_correct_pwm`

## Requirements
- R1: After synchronous reset the count is 0, the direction is up, the active compare value is 0x00, both flags are 0, `irq` is 0, and `pwm_out` is 0 while `out_mode` is 00.
- R2: On each cycle with `tick` high, the count advances one step along the sequence 0,1,…,255,254,…,1,0,1,… and never repeats 0 or 255. On a cycle with `tick` low, the count holds. A full period is 510 ticks.
- R3: `ovf_flag` is set one cycle after a tick taken while the count is 0.
- R4: `cmp_flag` is set one cycle after a tick taken while the count equals the active compare value. This holds on both the up slope and the down slope, and for every mode.
- R5: For an active compare value from 0x01 to 0xFE, a match on the up slope makes the output 0 in mode 10 and 1 in mode 11. A match on the down slope makes it 1 in mode 10 and 0 in mode 11. Between matches the output holds. In modes 00 and 01 the output is 0.
- R6: An active compare value of 0x00 fixes the output at 0 in mode 10 and at 1 in mode 11. A value of 0xFF fixes it at 1 in mode 10 and at 0 in mode 11. Neither value produces any toggling.
- R7: `cmp_val` is copied into the active compare register only on a tick taken while the count is 255. At any other time a change of `cmp_val` has no effect on the output.
- R8: A flag clears one cycle after its `*_clr` or `*_ack` input is high. If a set condition occurs in the same cycle as a clear, the set wins.
- R9: `irq` is high exactly when `glob_ie` is high and at least one flag is high together with its own enable (`ovf_ie` for `ovf_flag`, `cmp_ie` for `cmp_flag`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer-clock enable; the count advances on cycles where it is high |
| cmp_val | input | 8 | Compare value, staged until the top of the sweep |
| out_mode | input | 2 | 00/01 off, 10 non-inverting, 11 inverting |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cmp_ie | input | 1 | Compare interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| cmp_clr | input | 1 | Write-one-to-clear for the compare flag |
| ovf_ack | input | 1 | Overflow interrupt acknowledge |
| cmp_ack | input | 1 | Compare interrupt acknowledge |
| pwm_out | output | 1 | PWM output pin |
| ovf_flag | output | 1 | Overflow (left-zero) flag |
| cmp_flag | output | 1 | Compare-match flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures the spacing between overflow events. A counter that repeats 0 or 255 produces a spacing of 511 or 512 instead of 510, and a counter that wraps produces 256.

The bench changes the compare value in mid-sweep while `tick` is irregular. A design that loads the compare value early toggles the pin at a position that the reference model does not expect.

The bench sweeps every mode against 0x00, 0xFF and the values next to them. A design that lets the fixed-level values toggle, or swaps their polarity, shows up at once.

The bench also fires clears and acknowledges in the same cycle as set events. A design that lets a clear win loses a flag that the model still holds.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;

    localparam int unsigned CNT_W     = 8;
    localparam int unsigned NUM_FLAGS = 2;
    localparam int unsigned FLAG_OVF  = 0;
    localparam int unsigned FLAG_CMP  = 1;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } cnt_dir_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_RSVD   = 2'b01,
        OM_NONINV = 2'b10,
        OM_INV    = 2'b11
    } out_mode_e;

    // Level driven on a compare match; inv is the polarity bit of the mode.
    function automatic logic match_level(input logic inv, input cnt_dir_e d);
        return (d == DIR_UP) ? inv : ~inv;
    endfunction

    // Fixed level when the active compare sits at an end of the sweep.
    function automatic logic static_level(input logic inv, input logic at_max);
        return at_max ? ~inv : inv;
    endfunction

endpackage

// File: rtl/pwm_updown_counter.sv
`timescale 1ns/1ps
module pwm_updown_counter
    import pwm_timer_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output cnt_dir_e     dir,
    output logic         at_bottom,
    output logic         at_top
);
    localparam logic [W-1:0] CNT_MIN = '0;
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] ONE     = W'(1);

    logic [W-1:0] cnt_q;
    cnt_dir_e     dir_q;

    assign at_bottom = (cnt_q == CNT_MIN);
    assign at_top    = (cnt_q == CNT_MAX);
    assign cnt       = cnt_q;
    assign dir       = dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_MIN;
            dir_q <= DIR_UP;
        end else if (tick) begin
            unique case (dir_q)
                DIR_UP: begin
                    if (at_top) begin
                        cnt_q <= cnt_q - ONE;
                        dir_q <= DIR_DOWN;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                DIR_DOWN: begin
                    if (at_bottom) begin
                        cnt_q <= cnt_q + ONE;
                        dir_q <= DIR_UP;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                default: begin
                    cnt_q <= cnt_q;
                    dir_q <= dir_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwm_compare_out.sv
`timescale 1ns/1ps
module pwm_compare_out
    import pwm_timer_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  cnt_dir_e     dir,
    input  logic         at_top,
    input  logic [W-1:0] cmp_in,
    input  logic [1:0]   mode,
    output logic [W-1:0] ocr_act,
    output logic         match_ev,
    output logic         pwm_out
);
    localparam logic [W-1:0] VAL_MIN = '0;
    localparam logic [W-1:0] VAL_MAX = '1;

    logic [W-1:0] ocr_q;
    logic         wave_q;
    logic         ocr_is_min;
    logic         ocr_is_max;

    assign ocr_act    = ocr_q;
    assign match_ev   = tick && (cnt == ocr_q);
    assign ocr_is_min = (ocr_q == VAL_MIN);
    assign ocr_is_max = (ocr_q == VAL_MAX);

    // Staged compare value moves to the active register at the sweep top only.
    always_ff @(posedge clk) begin
        if (rst) begin
            ocr_q <= VAL_MIN;
        end else if (tick && at_top) begin
            ocr_q <= cmp_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q <= 1'b0;
        end else if (match_ev) begin
            wave_q <= match_level(mode[0], dir);
        end
    end

    always_comb begin
        if (!mode[1]) begin
            pwm_out = 1'b0;
        end else if (ocr_is_min || ocr_is_max) begin
            pwm_out = static_level(mode[0], ocr_is_max);
        end else begin
            pwm_out = wave_q;
        end
    end

endmodule

// File: rtl/pwm_event_flags.sv
`timescale 1ns/1ps
module pwm_event_flags
    import pwm_timer_pkg::*;
#(
    parameter int unsigned N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_w1,
    input  logic [N-1:0] ack,
    input  logic [N-1:0] ie,
    input  logic         gie,
    output logic [N-1:0] flag,
    output logic         irq
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
            end else if (set_ev[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_w1[i] || ack[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    assign flag = flag_q;
    assign irq  = gie && (|(flag_q & ie));

endmodule

// File: rtl/phase_correct_pwm.sv
`timescale 1ns/1ps
module phase_correct_pwm
    import pwm_timer_pkg::*;
#(
    parameter int unsigned CNT_W = pwm_timer_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [1:0]       out_mode,
    input  logic             ovf_ie,
    input  logic             cmp_ie,
    input  logic             glob_ie,
    input  logic             ovf_clr,
    input  logic             cmp_clr,
    input  logic             ovf_ack,
    input  logic             cmp_ack,
    output logic             pwm_out,
    output logic             ovf_flag,
    output logic             cmp_flag,
    output logic             irq
);
    logic [CNT_W-1:0]     cnt_w;
    logic [CNT_W-1:0]     ocr_w;
    cnt_dir_e             dir_w;
    logic                 bottom_w;
    logic                 top_w;
    logic                 match_w;
    logic [NUM_FLAGS-1:0] set_v, clr_v, ack_v, ie_v, flag_v;

    pwm_updown_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cnt       (cnt_w),
        .dir       (dir_w),
        .at_bottom (bottom_w),
        .at_top    (top_w)
    );

    pwm_compare_out #(.W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cnt      (cnt_w),
        .dir      (dir_w),
        .at_top   (top_w),
        .cmp_in   (cmp_val),
        .mode     (out_mode),
        .ocr_act  (ocr_w),
        .match_ev (match_w),
        .pwm_out  (pwm_out)
    );

    always_comb begin
        set_v[FLAG_OVF] = tick && bottom_w;
        set_v[FLAG_CMP] = match_w;
        clr_v[FLAG_OVF] = ovf_clr;
        clr_v[FLAG_CMP] = cmp_clr;
        ack_v[FLAG_OVF] = ovf_ack;
        ack_v[FLAG_CMP] = cmp_ack;
        ie_v[FLAG_OVF]  = ovf_ie;
        ie_v[FLAG_CMP]  = cmp_ie;
    end

    pwm_event_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_ev (set_v),
        .clr_w1 (clr_v),
        .ack    (ack_v),
        .ie     (ie_v),
        .gie    (glob_ie),
        .flag   (flag_v),
        .irq    (irq)
    );

    assign ovf_flag = flag_v[FLAG_OVF];
    assign cmp_flag = flag_v[FLAG_CMP];

endmodule

// File: rtl/pwm_timer_checker.sv
`timescale 1ns/1ps
module pwm_timer_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic [W-1:0] cnt,
    input logic [W-1:0] ocr_act,
    input logic [1:0]   out_mode,
    input logic         glob_ie,
    input logic         ovf_clr,
    input logic         ovf_ack,
    input logic         pwm_out,
    input logic         ovf_flag,
    input logic         cmp_flag,
    input logic         irq
);
    localparam logic [W-1:0] TOP  = '1;
    localparam logic [W-1:0] BOT  = '0;
    localparam logic [W-1:0] NEXT = W'(1);

    // R2: leaving zero goes to one
    a_r2_rise_from_bottom: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == BOT) |=> (cnt == NEXT));
    // R2: leaving the top goes one below it
    a_r2_fall_from_top: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == TOP) |=> (cnt == TOP - NEXT));
    // R2: no tick, no movement
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));
    // R3
    a_r3_ovf_raised: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == BOT) |=> ovf_flag);
    // R4
    a_r4_cmp_raised: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt == ocr_act) |=> cmp_flag);
    // R5
    a_r5_off_is_low: assert property (@(posedge clk) disable iff (rst)
        !out_mode[1] |-> !pwm_out);
    // R6
    a_r6_zero_fixed: assert property (@(posedge clk) disable iff (rst)
        (out_mode[1] && ocr_act == BOT) |-> (pwm_out == out_mode[0]));
    // R6
    a_r6_full_fixed: assert property (@(posedge clk) disable iff (rst)
        (out_mode[1] && ocr_act == TOP) |-> (pwm_out != out_mode[0]));
    // R7
    a_r7_ocr_held: assert property (@(posedge clk) disable iff (rst)
        !(tick && cnt == TOP) |=> $stable(ocr_act));
    // R8
    a_r8_ovf_cleared: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && (ovf_clr || ovf_ack) && !(tick && cnt == BOT)) |=> !ovf_flag);
    // R9
    a_r9_global_gate: assert property (@(posedge clk) disable iff (rst)
        !glob_ie |-> !irq);

endmodule

bind phase_correct_pwm pwm_timer_checker #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cnt      (cnt_w),
    .ocr_act  (ocr_w),
    .out_mode (out_mode),
    .glob_ie  (glob_ie),
    .ovf_clr  (ovf_clr),
    .ovf_ack  (ovf_ack),
    .pwm_out  (pwm_out),
    .ovf_flag (ovf_flag),
    .cmp_flag (cmp_flag),
    .irq      (irq)
);

// File: tb/tb_phase_correct_pwm.sv
`timescale 1ns/1ps
module tb_phase_correct_pwm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] cmp_val = 8'd0;
    logic [1:0] out_mode = 2'b00;
    logic       ovf_ie = 1'b0, cmp_ie = 1'b0, glob_ie = 1'b0;
    logic       ovf_clr = 1'b0, cmp_clr = 1'b0, ovf_ack = 1'b0, cmp_ack = 1'b0;
    logic       pwm_out, ovf_flag, cmp_flag, irq;

    always #2.5 clk = ~clk;

    phase_correct_pwm dut (
        .clk(clk), .rst(rst), .tick(tick), .cmp_val(cmp_val), .out_mode(out_mode),
        .ovf_ie(ovf_ie), .cmp_ie(cmp_ie), .glob_ie(glob_ie),
        .ovf_clr(ovf_clr), .cmp_clr(cmp_clr), .ovf_ack(ovf_ack), .cmp_ack(cmp_ack),
        .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .irq(irq)
    );

    // Behavioural reference state
    int m_cnt, m_up, m_ocr, m_wave, m_ovf, m_cmp;
    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic int exp_pwm();
        if (out_mode[1] == 1'b0) return 0;
        if (m_ocr == 0) return int'(out_mode[0]);
        if (m_ocr == 255) return int'(!out_mode[0]);
        return m_wave;
    endfunction

    function automatic int exp_irq();
        return (glob_ie && ((m_ovf != 0 && ovf_ie) || (m_cmp != 0 && cmp_ie))) ? 1 : 0;
    endfunction

    task automatic compare_all();
        string tag;
        if (m_ocr == 0 || m_ocr == 255) tag = "R6";
        else tag = "R5 R7";
        check(int'(pwm_out) == exp_pwm(), tag, int'(pwm_out), exp_pwm());
        check(int'(ovf_flag) == m_ovf, "R3 R8 ovf", int'(ovf_flag), m_ovf);
        check(int'(cmp_flag) == m_cmp, "R4 R8 cmp", int'(cmp_flag), m_cmp);
        check(int'(irq) == exp_irq(), "R9", int'(irq), exp_irq());
    endtask

    // One clock: advance the model with the current inputs, then compare.
    task automatic cycle();
        bit t, so, sc;
        int n_ocr;
        t  = tick;
        so = t && (m_cnt == 0);
        sc = t && (m_cnt == m_ocr);
        n_ocr = m_ocr;
        if (t && m_cnt == 255) n_ocr = int'(cmp_val);
        if (sc) m_wave = m_up ? int'(out_mode[0]) : int'(!out_mode[0]);
        if (so) m_ovf = 1; else if (ovf_clr || ovf_ack) m_ovf = 0;
        if (sc) m_cmp = 1; else if (cmp_clr || cmp_ack) m_cmp = 0;
        if (t) begin
            if (m_up != 0) begin
                if (m_cnt == 255) begin m_cnt = 254; m_up = 0; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin m_cnt = 1; m_up = 1; end
                else m_cnt = m_cnt - 1;
            end
        end
        m_ocr = n_ocr;
        @(posedge clk);
        #1;
        compare_all();
    endtask

    initial begin
        #(150000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int last_ovf;
        bit [1:0] modes [4];
        bit [7:0] edges [4];
        modes = '{2'b00, 2'b01, 2'b10, 2'b11};
        edges = '{8'd0, 8'd255, 8'd1, 8'd254};

        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        m_cnt = 0; m_up = 1; m_ocr = 0; m_wave = 0; m_ovf = 0; m_cmp = 0;
        // R1: reset state
        check(pwm_out == 1'b0, "R1 pwm", int'(pwm_out), 0);
        check(ovf_flag == 1'b0, "R1 ovf", int'(ovf_flag), 0);
        check(cmp_flag == 1'b0, "R1 cmp", int'(cmp_flag), 0);
        check(irq == 1'b0, "R1 irq", int'(irq), 0);

        // Phase A: continuous ticks, non-inverting, period spacing (R2)
        tick = 1; out_mode = 2'b10; cmp_val = 8'd100;
        ovf_ie = 1; cmp_ie = 1; glob_ie = 1;
        last_ovf = -1;
        for (int i = 0; i < 1600; i++) begin
            cycle();
            if (ovf_flag) begin
                if (last_ovf >= 0)
                    check(i - last_ovf == 510, "R2 period", i - last_ovf, 510);
                last_ovf = i;
            end
            ovf_clr = ovf_flag;
            cmp_clr = cmp_flag;
        end
        ovf_clr = 0; cmp_clr = 0;

        // Phase B: irregular ticks, inverting, mid-sweep compare changes (R7)
        out_mode = 2'b11;
        for (int i = 0; i < 4000; i++) begin
            tick = ($urandom % 3) != 0;
            if (i % 137 == 0) cmp_val = 8'(1 + ($urandom % 254));
            ovf_ack = ($urandom % 8) == 0;
            cmp_ack = ($urandom % 8) == 0;
            if (($urandom % 50) == 0) glob_ie = ~glob_ie;
            cycle();
        end
        ovf_ack = 0; cmp_ack = 0; glob_ie = 1;

        // Phase C: every mode against edge compare values (R5, R6)
        tick = 1;
        for (int mi = 0; mi < 4; mi++) begin
            for (int ei = 0; ei < 4; ei++) begin
                out_mode = modes[mi];
                cmp_val  = edges[ei];
                for (int k = 0; k < 600; k++) begin
                    cmp_clr = cmp_flag;
                    ovf_clr = ovf_flag;
                    cycle();
                end
            end
        end

        // Phase D: clears and acks racing set events (R8, R9)
        out_mode = 2'b10; cmp_val = 8'd0;
        for (int i = 0; i < 1500; i++) begin
            ovf_clr = $urandom % 2; cmp_clr = $urandom % 2;
            ovf_ack = $urandom % 3 == 0; cmp_ack = $urandom % 3 == 0;
            ovf_ie = $urandom % 2; cmp_ie = $urandom % 2; glob_ie = $urandom % 2;
            cycle();
        end
        finish_run();
    end

endmodule